// File: doc/BRIEF.md
# Seven-slot display link serializer

This block takes one 28-bit pixel word in every pixel-clock period and sends it out as four serial data lanes. Each lane carries seven bit slots per pixel period, and a fifth lane carries a framed copy of the pixel clock. The word holds 24 colour bits and four timing and control bits. The block runs entirely on the bit-rate clock, which is seven times the pixel clock and phase-locked to it. The pixel clock itself is an ordinary input. The block finds its falling edge and captures the word at the first bit-clock edge at which the pixel clock reads low.

The link has a fixed rate and cannot stall, so the data input has no valid/ready handshake. The word is taken on every falling pixel edge, and the source must hold it stable across that edge. A single output-enable flag stands for the state of the line drivers: high means driving, low means high impedance. While the flag is low, every lane is held at 0. The flag rises only after a lock-settle wait. The wait is `LOCK_CYCLES` bit clocks, and the default models about 10 ms at a 280 MHz bit rate. Power-down drops the flag within one bit clock, and releasing it starts the whole wait again. The pixel period may lie between 25 and 50 ns, and the bit clock must follow it.

Top module: `ser7_link_tx`

## Requirements
- R1: The word on `pix_word` is captured at the bit-clock rising edge where `pix_clk` is sampled low after being high the edge before. Values presented after that edge do not enter the current pixel.
- R2: Lane i (`lane_data[i]`) carries word bits 7i to 7i+6, lowest bit first. Slot 0 is driven in the bit period that starts at the capture edge, and slot k in the k-th period after it.
- R3: `lane_clk` sends 1,1,0,0,0,1,1 in slots 0 to 6 of each pixel period, aligned to the data slots.
- R4: The word layout is colour in bits 0–23, line sync in bit 24, frame sync in bit 25, data-ready in bit 26 and the general control bit in bit 27. The four timing and control bits therefore appear on lane 3 in slots 3 to 6.
- R5: Latency is one pixel period. Changing `pix_word` after the capture edge does not alter the seven slots of the word already captured.
- R6: After reset release, `out_en` stays low for exactly `LOCK_CYCLES` bit clocks. It is high in the period after the `LOCK_CYCLES`-th edge.
- R7: When `pwr_dn` is sampled high, `out_en` and all lanes are low from the next bit period on. They stay low for as long as `pwr_dn` is high, whatever `pix_word` and `pix_clk` do.
- R8: Releasing `pwr_dn` restarts the lock wait. `out_en` returns exactly `LOCK_CYCLES` bit clocks after the release.
- R9: Synchronous active-low `rst_n` clears the shifters and the lock counter. `out_en` and all lanes are low in the period after an edge with `rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit-rate clock, seven times the pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_clk | input | 1 | Pixel clock, sampled by clk_bit |
| pwr_dn | input | 1 | Power-down request, active high |
| pix_word | input | 28 | Pixel word: colour, syncs, data-ready, control |
| lane_data | output | 4 | Serial data lanes, one bit per slot |
| lane_clk | output | 1 | Framed forwarded clock lane |
| out_en | output | 1 | Drivers active; low stands for high impedance |

## Verification
A shifter that is out of step, or one loaded with the wrong bits, shows on the lanes within one pixel period. The fault appears as a wrong slot-0 value at the bit period after a capture edge, or as a clock-lane frame shifted against the data. A lock counter that runs short or long moves the rise of `out_en` by the same number of bit clocks. A lost power-down path leaves a lane toggling one bit period after `pwr_dn` is sampled.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_SLOTS = 7;
  // about 10 ms at a 280 MHz bit clock
  localparam int unsigned DEF_LOCK  = 2_800_000;
  // forwarded clock frame, slot 0 in bit 0
  localparam logic [6:0]  CLK_FRAME = 7'b1100011;
  // word field positions
  localparam int unsigned FLD_LSYNC = 24;
  localparam int unsigned FLD_FSYNC = 25;
  localparam int unsigned FLD_DRDY  = 26;
  localparam int unsigned FLD_CTRL  = 27;
endpackage

// File: rtl/ser7_fall_det.sv
module ser7_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_clk,
  output logic fall
);
  logic pix_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pix_q <= 1'b0;
    else        pix_q <= pix_clk;
  end

  assign fall = pix_q & ~pix_clk;
endmodule

// File: rtl/ser7_lock_timer.sv
module ser7_lock_timer #(
  parameter int unsigned LOCK_CYCLES = 2_800_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  output logic locked
);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1) < 1 ? 1 : $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || pwr_dn)  cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign locked = (cnt == LIMIT);
endmodule

// File: rtl/ser7_lane.sv
module ser7_lane #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [SLOTS-1:0] load_bits,
  output logic             bit_q
);
  localparam int unsigned SW = SLOTS - 1;

  logic [SW-1:0] rest;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      bit_q <= 1'b0;
      rest  <= '0;
    end else if (load) begin
      bit_q <= load_bits[0];
      rest  <= load_bits[SLOTS-1:1];
    end else begin
      bit_q <= rest[0];
      rest  <= rest >> 1;
    end
  end
endmodule

// File: rtl/ser7_link_tx.sv
module ser7_link_tx #(
  parameter int unsigned LANES       = ser7_pkg::DEF_LANES,
  parameter int unsigned SLOTS       = ser7_pkg::DEF_SLOTS,
  parameter int unsigned LOCK_CYCLES = ser7_pkg::DEF_LOCK,
  parameter logic [SLOTS-1:0] CLK_PAT = SLOTS'(ser7_pkg::CLK_FRAME),
  localparam int unsigned WORD_W     = LANES * SLOTS
) (
  input  logic              clk_bit,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              pwr_dn,
  input  logic [WORD_W-1:0] pix_word,
  output logic [LANES-1:0]  lane_data,
  output logic              lane_clk,
  output logic              out_en
);
  logic             fall;
  logic             locked;
  logic [LANES-1:0] data_q;
  logic             clk_q;

  ser7_fall_det u_fall (
    .clk     (clk_bit),
    .rst_n   (rst_n),
    .pix_clk (pix_clk),
    .fall    (fall)
  );

  ser7_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk_bit),
    .rst_n  (rst_n),
    .pwr_dn (pwr_dn),
    .locked (locked)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    ser7_lane #(.SLOTS(SLOTS)) u_lane (
      .clk       (clk_bit),
      .rst_n     (rst_n),
      .clr       (pwr_dn),
      .load      (fall),
      .load_bits (pix_word[i*SLOTS +: SLOTS]),
      .bit_q     (data_q[i])
    );
  end

  ser7_lane #(.SLOTS(SLOTS)) u_clk_lane (
    .clk       (clk_bit),
    .rst_n     (rst_n),
    .clr       (pwr_dn),
    .load      (fall),
    .load_bits (CLK_PAT),
    .bit_q     (clk_q)
  );

  // drivers off: lanes held low
  assign out_en    = locked;
  assign lane_data = data_q & {LANES{locked}};
  assign lane_clk  = clk_q & locked;
endmodule

// File: rtl/ser7_link_tx_chk.sv
module ser7_link_tx_chk #(
  parameter int unsigned LANES       = 4,
  parameter int unsigned SLOTS       = 7,
  parameter int unsigned LOCK_CYCLES = 2_800_000,
  parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011,
  localparam int unsigned WORD_W     = LANES * SLOTS
) (
  input logic              clk_bit,
  input logic              rst_n,
  input logic              pix_clk,
  input logic              pwr_dn,
  input logic [WORD_W-1:0] pix_word,
  input logic [LANES-1:0]  lane_data,
  input logic              lane_clk,
  input logic              out_en
);
  localparam int unsigned CW = $clog2(LOCK_CYCLES + 1) < 1 ? 1 : $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_CYCLES);

  logic [CW-1:0]    since_up;
  logic [LANES-1:0] first_bits;

  always_ff @(posedge clk_bit) begin
    if (!rst_n || pwr_dn)       since_up <= '0;
    else if (since_up != LIMIT) since_up <= since_up + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) first_bits[i] = pix_word[i*SLOTS];
  end

  // R2
  slot0_data_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ($fell(pix_clk) && out_en && !pwr_dn) |=> lane_data == $past(first_bits));

  // R3
  slot0_clk_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    ($fell(pix_clk) && out_en && !pwr_dn) |=> lane_clk == CLK_PAT[0]);

  // R6
  lock_wait_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    out_en |-> since_up == LIMIT);

  // R7
  pwr_off_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    pwr_dn |=> !out_en);

  // R7
  quiet_lanes_chk: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !out_en |-> (lane_data == '0 && !lane_clk));
endmodule

bind ser7_link_tx ser7_link_tx_chk #(
  .LANES(LANES), .SLOTS(SLOTS), .LOCK_CYCLES(LOCK_CYCLES), .CLK_PAT(CLK_PAT)
) u_chk (.*);

// File: tb/ser7_link_tx_bench.sv
module ser7_link_tx_bench;
  localparam int LOCK = 20;

  logic        clk_bit = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_clk = 1'b1;
  logic        pwr_dn = 1'b0;
  logic [27:0] pix_word = '0;
  logic [3:0]  lane_data;
  logic        lane_clk;
  logic        out_en;

  int checks = 0;
  int errors = 0;
  int phase = 0;
  logic [6:0] frame = 7'b1100011;

  ser7_link_tx #(.LOCK_CYCLES(LOCK)) u_ser7_link_tx (
    .clk_bit, .rst_n, .pix_clk, .pwr_dn, .pix_word,
    .lane_data, .lane_clk, .out_en
  );

  always #10 clk_bit = ~clk_bit;

  // pixel clock: high in phases 0..3, low in 4..6
  always @(negedge clk_bit) begin
    phase   <= (phase == 6) ? 0 : phase + 1;
    pix_clk <= ((phase == 6) ? 0 : phase + 1) < 4;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_bit); #1;
  endtask

  task automatic wait_phase(input int p);
    do tick(); while (phase != p);
  endtask

  // sets the word when phase == set_at, then checks all seven slots
  task automatic send_word(input logic [27:0] w, input int set_at, input string tag);
    wait_phase(set_at);
    pix_word = w;
    wait_phase(5);
    for (int k = 0; k < 7; k++) begin
      logic [3:0] exp;
      exp = {w[21+k], w[14+k], w[7+k], w[k]};
      check(lane_data == exp, (k > 0) ? {"R2 R5 ", tag} : {"R2 ", tag}, lane_data, exp);
      check(lane_clk == frame[k], "R3", lane_clk, frame[k]);
      if (k == 0) pix_word = ~w;
      if (k < 6) tick();
    end
  endtask

  task automatic measure_lock(input string req);
    int n = 0;
    do begin tick(); n++; end while (!out_en && n < 200);
    check(n == LOCK, req, n, LOCK);
  endtask

  task automatic test_reset();
    tick();
    check(out_en == 0 && lane_data == 0 && lane_clk == 0, "R9 reset state",
          {out_en, lane_clk, lane_data}, 0);
    rst_n = 1'b1;
    measure_lock("R6 lock wait after reset");
  endtask

  task automatic test_patterns();
    send_word(28'h5555555, 0, "alt");
    send_word(28'hFFFFFFF, 0, "ones");
    send_word(28'h0000001, 0, "single");
    send_word(28'h8C3A5E1, 0, "mixed");
    // R4: syncs, data-ready, control on lane 3 slots 3..6
    send_word({1'b1, 1'b0, 1'b1, 1'b0, 24'h000000}, 0, "R4 fields");
    send_word({1'b0, 1'b1, 1'b0, 1'b1, 24'hABCDEF}, 0, "R4 fields");
  endtask

  task automatic test_capture_edge();
    // R1: a word set just as pix_clk goes low is still taken
    send_word(28'h1234567, 4, "R1 late set");
    send_word(28'hEDCBA98, 3, "R1 pre-fall");
  endtask

  task automatic test_power_down();
    tick();
    pwr_dn = 1'b1;
    tick();
    check(!out_en && lane_data == 0 && !lane_clk, "R7 off next period",
          {out_en, lane_clk, lane_data}, 0);
    for (int i = 0; i < 20; i++) begin
      pix_word = (i % 2) ? 28'hFFFFFFF : 28'h0F0F0F0;
      tick();
      if (i % 5 == 0)
        check(!out_en && lane_data == 0 && !lane_clk, "R7 held off",
              {out_en, lane_clk, lane_data}, 0);
    end
    pwr_dn = 1'b0;
    measure_lock("R8 relock after power-down");
    send_word(28'h3C3C3C3, 0, "R8 after relock");
  endtask

  task automatic test_mid_reset();
    wait_phase(6);
    rst_n = 1'b0;
    tick();
    check(!out_en && lane_data == 0 && !lane_clk, "R9 mid-stream reset",
          {out_en, lane_clk, lane_data}, 0);
    rst_n = 1'b1;
    measure_lock("R6 lock after second reset");
    send_word(28'h6A6A6A6, 0, "R9 after reset");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick();
    tick();
    test_reset();
    test_patterns();
    test_capture_edge();
    test_power_down();
    test_mid_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule